// File: doc/BRIEF.md
# SPI Pin-Control Port

This block is a memory-mapped peripheral that lets software run an SPI bus in mode 0 by writing pin levels one at a time. A single pin register carries the serial clock, the master-out data line and a set of chip-select lines. The hardware adds one thing on top of software control: each time a write raises the clock bit, it shifts the level on the slave's data line into a capture register. Software reads that register back once a word is done.

When the manual-mode bit is clear, the pin register has no effect on the bus. The clock, data-out and chip-select pins then pass straight through from a separate flash read engine, which reaches the block over its engine inputs. The four registers sit on a simple 32-bit write/read port. Writes take effect at the clock edge that accepts them. Reads are combinational from the addressed register.

Top module: `spi_pp_top`

## Requirements
- R1: After reset, the registers at offsets 0x0, 0x4, 0x8 and 0xC all read zero, and the bus pins follow the engine inputs.
- R2: Offsets 0x0 (mode), 0x4 (control) and 0x8 (pins) each store all 32 bits of the last write and read them back unchanged. Bit 0 of the mode register selects manual mode.
- R3: With manual mode on, the pins take their levels from the pin register from the edge that accepts the write: bit 0 drives data-out, bit 8 drives the serial clock, and bit 16+n drives chip-select n for n = 0..2.
- R4: With manual mode off, the clock, data-out and chip-select pins equal the engine inputs in the same cycle, whatever the pin register holds.
- R5: A pin-register write made with manual mode on, that sets bit 8 while the stored bit 8 is 0, shifts the capture register left by one. The data-in level sampled at that write's clock edge enters bit 0.
- R6: The capture register keeps its value on every other cycle. This includes writes that keep the clock bit high, writes that lower it, and clock-raising writes made while manual mode is off.
- R7: Offset 0xC reads the capture register. Writes to offset 0xC are ignored.
- R8: Any address other than 0x0, 0x4, 0x8 or 0xC reads zero, and writes to it change no register. This includes misaligned addresses and offsets of 0x10 and above.
- R9: A mode 0 word of 1 to 32 bits, sent MSB first by placing data-out with the clock low, raising the clock, and finally lowering it, leaves the received bits in the low bits of the capture register. The first bit received ends up as the most significant of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_clk_i | input | 1 | Serial clock from the flash read engine |
| eng_mosi_i | input | 1 | Data-out from the flash read engine |
| eng_cs_i | input | NUM_CS | Chip-selects from the flash read engine |
| spi_miso_i | input | 1 | Data line from the slave |
| spi_clk_o | output | 1 | Serial clock pin |
| spi_mosi_o | output | 1 | Data-out pin |
| spi_cs_o | output | NUM_CS | Chip-select pins |

## Verification
The assertions assume that at most one register write arrives per cycle. They also assume that the data-in line is stable around the clock edge that accepts a clock-raising write. Both assumptions let a write's effect be pinned to the following cycle. The bench drives every bus input and the data-in line only at the falling clock edge. It issues one write at a time and holds data-in steady across each clock-raising write, so it stays within those assumptions. Engine inputs change only while manual mode is off, or are checked combinationally.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;

    localparam int REG_W = 32;

    // bit positions that the pin logic and software agree on
    localparam int MODE_MANUAL_BIT = 0;
    localparam int PIN_DO_BIT      = 0;
    localparam int PIN_CLK_BIT     = 8;
    localparam int PIN_CS_LSB      = 16;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_PINS  = 2'd2,
        SEL_SHIFT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     valid;
        reg_sel_e sel;
    } decode_t;

    // word-aligned offsets 0x0..0xC are mapped, everything else is not
    function automatic decode_t decode_addr(input logic [REG_W-1:0] addr);
        decode_t d;
        d.valid = (addr[1:0] == 2'b00) && (addr[REG_W-1:4] == '0);
        d.sel   = reg_sel_e'(addr[3:2]);
        return d;
    endfunction

endpackage

// File: rtl/spi_pp_regs.sv
module spi_pp_regs
    import spi_pp_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int SHIFT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic [SHIFT_W-1:0] shift_q,
    output logic [REG_W-1:0]   bus_rdata,
    output logic [REG_W-1:0]   mode_q,
    output logic [REG_W-1:0]   ctrl_q,
    output logic [REG_W-1:0]   pin_q,
    output logic               pin_wr
);

    decode_t dec;
    logic    wr_mode;
    logic    wr_ctrl;

    assign dec = decode_addr(REG_W'(bus_addr));

    always_comb begin
        wr_mode = bus_wr && dec.valid && (dec.sel == SEL_MODE);
        wr_ctrl = bus_wr && dec.valid && (dec.sel == SEL_CTRL);
        pin_wr  = bus_wr && dec.valid && (dec.sel == SEL_PINS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ctrl_q <= '0;
            pin_q  <= '0;
        end else begin
            if (wr_mode) mode_q <= bus_wdata;
            if (wr_ctrl) ctrl_q <= bus_wdata;
            if (pin_wr)  pin_q  <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (dec.valid) begin
            unique case (dec.sel)
                SEL_MODE:  bus_rdata = mode_q;
                SEL_CTRL:  bus_rdata = ctrl_q;
                SEL_PINS:  bus_rdata = pin_q;
                SEL_SHIFT: bus_rdata = REG_W'(shift_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_pp_shift.sv
module spi_pp_shift #(
    parameter int SHIFT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pin_wr,
    input  logic               manual,
    input  logic               clk_new,
    input  logic               clk_old,
    input  logic               miso,
    output logic [SHIFT_W-1:0] shift_q
);

    logic capture;

    // a software-made rising edge of the serial clock
    assign capture = pin_wr && manual && clk_new && !clk_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else if (capture) begin
            shift_q <= {shift_q[SHIFT_W-2:0], miso};
        end
    end

endmodule

// File: rtl/spi_pp_pinmux.sv
module spi_pp_pinmux #(
    parameter int NUM_CS = 3
) (
    input  logic              manual,
    input  logic              man_clk,
    input  logic              man_mosi,
    input  logic [NUM_CS-1:0] man_cs,
    input  logic              eng_clk,
    input  logic              eng_mosi,
    input  logic [NUM_CS-1:0] eng_cs,
    output logic              pin_clk,
    output logic              pin_mosi,
    output logic [NUM_CS-1:0] pin_cs
);

    assign pin_clk  = manual ? man_clk  : eng_clk;
    assign pin_mosi = manual ? man_mosi : eng_mosi;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign pin_cs[i] = manual ? man_cs[i] : eng_cs[i];
    end

endmodule

// File: rtl/spi_pp_top.sv
module spi_pp_top
    import spi_pp_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int NUM_CS  = 3,
    parameter int SHIFT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_clk_i,
    input  logic              eng_mosi_i,
    input  logic [NUM_CS-1:0] eng_cs_i,
    input  logic              spi_miso_i,
    output logic              spi_clk_o,
    output logic              spi_mosi_o,
    output logic [NUM_CS-1:0] spi_cs_o
);

    logic [REG_W-1:0]   mode_q;
    logic [REG_W-1:0]   ctrl_q;
    logic [REG_W-1:0]   pin_q;
    logic [SHIFT_W-1:0] shift_q;
    logic               pin_wr;
    logic               manual;

    assign manual = mode_q[MODE_MANUAL_BIT];

    spi_pp_regs #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .shift_q   (shift_q),
        .bus_rdata (bus_rdata),
        .mode_q    (mode_q),
        .ctrl_q    (ctrl_q),
        .pin_q     (pin_q),
        .pin_wr    (pin_wr)
    );

    spi_pp_shift #(.SHIFT_W(SHIFT_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .pin_wr  (pin_wr),
        .manual  (manual),
        .clk_new (bus_wdata[PIN_CLK_BIT]),
        .clk_old (pin_q[PIN_CLK_BIT]),
        .miso    (spi_miso_i),
        .shift_q (shift_q)
    );

    spi_pp_pinmux #(.NUM_CS(NUM_CS)) u_pinmux (
        .manual   (manual),
        .man_clk  (pin_q[PIN_CLK_BIT]),
        .man_mosi (pin_q[PIN_DO_BIT]),
        .man_cs   (pin_q[PIN_CS_LSB +: NUM_CS]),
        .eng_clk  (eng_clk_i),
        .eng_mosi (eng_mosi_i),
        .eng_cs   (eng_cs_i),
        .pin_clk  (spi_clk_o),
        .pin_mosi (spi_mosi_o),
        .pin_cs   (spi_cs_o)
    );

endmodule

// File: rtl/spi_pp_chk.sv
module spi_pp_chk #(
    parameter int ADDR_W  = 5,
    parameter int NUM_CS  = 3,
    parameter int SHIFT_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               spi_miso_i,
    input logic               spi_clk_o,
    input logic               spi_mosi_o,
    input logic [NUM_CS-1:0]  spi_cs_o,
    input logic [31:0]        mode_q,
    input logic [31:0]        ctrl_q,
    input logic [31:0]        pin_q,
    input logic [SHIFT_W-1:0] shift_q
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(8);

    logic wr_ctrl, wr_pins, wr_unmapped, rise_wr;

    assign wr_ctrl     = bus_wr && (bus_addr == A_CTRL);
    assign wr_pins     = bus_wr && (bus_addr == A_PINS);
    assign wr_unmapped = bus_wr && ((bus_addr[1:0] != 2'b00) || ((bus_addr >> 2) >= ADDR_W'(4)));
    assign rise_wr     = wr_pins && mode_q[0] && bus_wdata[8] && !pin_q[8];

    // R2
    a_r2_ctrl_store: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_q == $past(bus_wdata)));

    // R3
    a_r3_pins_follow: assert property (@(posedge clk) disable iff (rst)
        (wr_pins && mode_q[0]) |=>
            (spi_clk_o == $past(bus_wdata[8])) && (spi_mosi_o == $past(bus_wdata[0])) &&
            (spi_cs_o == $past(bus_wdata[16 +: NUM_CS])));

    // R5
    a_r5_shift_in: assert property (@(posedge clk) disable iff (rst)
        rise_wr |=> (shift_q == {$past(shift_q[SHIFT_W-2:0]), $past(spi_miso_i)}));

    // R6
    a_r6_shift_hold: assert property (@(posedge clk) disable iff (rst)
        !rise_wr |=> $stable(shift_q));

    // R8
    a_r8_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
        wr_unmapped |=> ($stable(mode_q) && $stable(ctrl_q) && $stable(pin_q)));

endmodule

bind spi_pp_top spi_pp_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .SHIFT_W(SHIFT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .spi_miso_i (spi_miso_i),
    .spi_clk_o  (spi_clk_o),
    .spi_mosi_o (spi_mosi_o),
    .spi_cs_o   (spi_cs_o),
    .mode_q     (mode_q),
    .ctrl_q     (ctrl_q),
    .pin_q      (pin_q),
    .shift_q    (shift_q)
);

// File: tb/spi_pp_top_tb.sv
module spi_pp_top_tb;

    localparam int ADDR_W = 5;
    localparam int NUM_CS = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              eng_clk_i = 1'b0;
    logic              eng_mosi_i = 1'b0;
    logic [NUM_CS-1:0] eng_cs_i = '0;
    logic              spi_miso_i = 1'b0;
    logic              spi_clk_o;
    logic              spi_mosi_o;
    logic [NUM_CS-1:0] spi_cs_o;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // bench-side model of the design state, built from the requirements
    logic [31:0] exp_sh = '0;
    logic        man_on = 1'b0;
    logic        last_clk = 1'b0;

    always #4 clk = ~clk;

    spi_pp_top #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .SHIFT_W(32)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_clk_i(eng_clk_i), .eng_mosi_i(eng_mosi_i), .eng_cs_i(eng_cs_i),
        .spi_miso_i(spi_miso_i), .spi_clk_o(spi_clk_o), .spi_mosi_o(spi_mosi_o),
        .spi_cs_o(spi_cs_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_mode(input logic [31:0] d);
        wr(5'h00, d);
        man_on = d[0];
    endtask

    task automatic wr_pins(input logic [31:0] d);
        logic m;
        m = spi_miso_i;
        wr(5'h08, d);
        if (man_on && d[8] && !last_clk) exp_sh = {exp_sh[30:0], m};
        last_clk = d[8];
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pins_chk(input logic c, input logic m, input logic [NUM_CS-1:0] cs, input string tag);
        #1;
        chk({tag, " clk"},  32'(spi_clk_o),  32'(c));
        chk({tag, " mosi"}, 32'(spi_mosi_o), 32'(m));
        chk({tag, " cs"},   32'(spi_cs_o),   32'(cs));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_chk(5'h00, 32'h0, "R1 mode");
        rd_chk(5'h04, 32'h0, "R1 ctrl");
        rd_chk(5'h08, 32'h0, "R1 pins");
        rd_chk(5'h0C, 32'h0, "R1 shift");
        eng_clk_i = 1'b1; eng_mosi_i = 1'b0; eng_cs_i = 3'b101;
        pins_chk(1'b1, 1'b0, 3'b101, "R1 engine");

        // R4: engine pass-through, all input combinations
        for (int v = 0; v < 32; v++) begin
            eng_clk_i = v[0]; eng_mosi_i = v[1]; eng_cs_i = v[4:2];
            pins_chk(v[0], v[1], v[4:2], "R4 sweep");
        end

        // R4 and R6: pin writes while manual is off drive nothing and capture nothing
        eng_clk_i = 1'b0; eng_mosi_i = 1'b1; eng_cs_i = 3'b010;
        spi_miso_i = 1'b1;
        wr_pins(32'h0005_0101);
        pins_chk(1'b0, 1'b1, 3'b010, "R4 manual off");
        rd_chk(5'h0C, exp_sh, "R6 no capture when manual off");
        wr_pins(32'h0000_0000);

        // R2: full-width store and readback
        wr_mode(32'hFFFF_FFFE);
        wr(5'h04, 32'h0000_0043);
        wr_pins(32'hDEAD_BEEE);
        rd_chk(5'h00, 32'hFFFF_FFFE, "R2 mode");
        rd_chk(5'h04, 32'h0000_0043, "R2 ctrl");
        rd_chk(5'h08, 32'hDEAD_BEEE, "R2 pins");
        wr(5'h04, 32'h5A5A_A5A5);
        rd_chk(5'h04, 32'h5A5A_A5A5, "R2 ctrl second");
        wr_pins(32'h0000_0000);

        // manual on; R3 sweep of all pin combinations
        wr_mode(32'h0000_0001);
        rd_chk(5'h00, 32'h0000_0001, "R2 mode manual");
        for (int v = 0; v < 32; v++) begin
            spi_miso_i = v[2];
            wr_pins({13'h0, v[4:2], 7'h0, v[0], 7'h0, v[1]});
            pins_chk(v[0], v[1], v[4:2], "R3 sweep");
            rd_chk(5'h0C, exp_sh, "R5 capture during sweep");
        end

        // R7: writes to the capture offset are ignored
        wr(5'h0C, 32'h1234_5678);
        rd_chk(5'h0C, exp_sh, "R7 shift write ignored");

        // R8: unmapped and misaligned addresses
        wr_pins(32'h0002_0000);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        wr(5'h09, 32'hFFFF_FFFF);
        wr(5'h01, 32'h0000_0000);
        rd_chk(5'h10, 32'h0, "R8 read 0x10");
        rd_chk(5'h14, 32'h0, "R8 read 0x14");
        rd_chk(5'h0A, 32'h0, "R8 read misaligned");
        rd_chk(5'h00, 32'h0000_0001, "R8 mode untouched");
        rd_chk(5'h04, 32'h5A5A_A5A5, "R8 ctrl untouched");
        rd_chk(5'h08, 32'h0002_0000, "R8 pins untouched");
        rd_chk(5'h0C, exp_sh, "R8 shift untouched");
        pins_chk(1'b0, 1'b0, 3'b010, "R8 pins held");

        // R9: mode 0 words of every length, several patterns
        for (int n = 1; n <= 32; n++) begin
            for (int p = 0; p < 3; p++) begin
                logic [31:0] tx, rx, msk, cs_w;
                tx   = (32'hA5C3_96E1 ^ (32'(n) * 32'h0101_0101)) + 32'(p) * 32'h3141_5926;
                rx   = ~tx ^ (32'(p) * 32'h0F0F_1234) ^ 32'(n);
                msk  = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
                cs_w = 32'h1 << (16 + p);
                for (int b = n - 1; b >= 0; b--) begin
                    wr_pins(cs_w | 32'(tx[b]));
                    pins_chk(1'b0, tx[b], cs_w[18:16], "R9 bit setup");
                    spi_miso_i = rx[b];
                    wr_pins(cs_w | 32'h100 | 32'(tx[b]));
                    pins_chk(1'b1, tx[b], cs_w[18:16], "R9 clock high");
                end
                wr_pins(cs_w | 32'(tx[0]));
                pins_chk(1'b0, tx[0], cs_w[18:16], "R9 clock returns low");
                bus_addr = 5'h0C;
                #1;
                chk("R9 received word", bus_rdata & msk, rx & msk);
                chk("R5 capture register", bus_rdata, exp_sh);
            end
        end

        // R6: clock held high, then lowered, makes no capture
        spi_miso_i = 1'b1;
        wr_pins(32'h0000_0100);
        rd_chk(5'h0C, exp_sh, "R5 single rise");
        spi_miso_i = 1'b0;
        wr_pins(32'h0000_0101);
        rd_chk(5'h0C, exp_sh, "R6 clock stays high");
        wr_pins(32'h0000_0000);
        rd_chk(5'h0C, exp_sh, "R6 clock lowered");
        repeat (4) @(negedge clk);
        rd_chk(5'h0C, exp_sh, "R6 idle");

        // R4: leaving manual mode hands the pins back to the engine
        eng_clk_i = 1'b1; eng_mosi_i = 1'b1; eng_cs_i = 3'b111;
        wr_mode(32'h0000_0000);
        pins_chk(1'b1, 1'b1, 3'b111, "R4 manual off again");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule